// File: doc/BRIEF.md
# Burst SRAM Command and Byte-Write Decoder

This block sits at the control input of a synchronous burst SRAM. On each rising clock edge it samples the chip enables, the two address strobes, the advance input and the write controls. It turns that sample into a single operation code and registers it. The possible operations are deselect, the start of a read or write burst, the continuation of a burst at the next address, and the suspension of a burst at the current address.

Next to the code it registers an address-load pulse, a counter-advance pulse and one write strobe per byte lane. The counter, the array and the output drivers downstream use these.

The chip enables count only in a cycle where a strobe is low. A burst that is in progress keeps running through cycles with both strobes high, whatever the enables do. The processor strobe always starts a read. The global write input takes precedence over the per-lane selects.

Top module: `sbc_cmd_decoder`

## Requirements
- R1: While reset is held, and on the first cycle after it, `op` is 0 (deselect), and `addr_load`, `cnt_adv` and `byte_we` are all zero.
- R2: When `ce1_n` is high and either strobe is low, the next `op` is 0 (deselect) with no load and no write strobes. This includes a cycle where only the processor strobe is low.
- R3: The secondary enable condition holds only when `ce2` is 1 and `ce3_n` is 0. A strobe cycle with that condition false gives `op` 0.
- R4: With all enables true and `ps_n` low, `op` becomes 1 (read begin) whatever the write inputs and `cs_n` are. `addr_load` is high for that one cycle and `byte_we` is zero.
- R5: With all enables true, `ps_n` high and `cs_n` low, `op` becomes 2 (write begin) if the write decode selects at least one lane, and otherwise 1 (read begin). `addr_load` pulses in either case.
- R6: With both strobes high and a burst in progress, `adv_n` low gives continue and `adv_n` high gives suspend. Continue is 4 for a write and 3 for a read. Suspend is 6 for a write and 5 for a read. `cnt_adv` is high only on continue. The chip enables have no effect on these cycles.
- R7: A begin cycle starts a burst and a deselect ends it. With both strobes high and no burst in progress (after reset or after a deselect), `op` is 0.
- R8: With `gw_n` low, a write operation drives all four bits of `byte_we` high, whatever `bwe_n` and `bsel_n` are.
- R9: With `gw_n` high and `bwe_n` low, a write operation drives `byte_we[i]` high exactly for the lanes where `bsel_n[i]` is low. With `bwe_n` high, or with all selects high, the cycle is a read.
- R10: Every output is registered and reflects the inputs sampled at the previous rising edge. A new begin can be taken on every consecutive cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce3_n | input | 1 | Secondary chip enable, active low |
| ps_n | input | 1 | Processor address strobe, active low |
| cs_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low |
| op | output | 3 | Registered operation code (0 to 6) |
| addr_load | output | 1 | Load the external address (begin cycles) |
| cnt_adv | output | 1 | Advance the burst counter (continue cycles) |
| byte_we | output | 4 | Per-lane write strobes, active high |

## Verification
The assertions check every cycle that the load and advance pulses are never high together and that each pulse matches its class of operation. They also check that write strobes appear only on write operations. They check that a disabled strobe cycle, and a strobe-free cycle after a deselect, both produce deselect, and that an enabled processor strobe produces a read begin.

The exact lane pattern for each mix of global write, byte-write enable and selects can only be shown by the bench's scenarios. The same holds for a burst that survives enables dropping in mid-burst, and for the choice between continue and suspend. The bench's own model predicts these outcomes for directed sequences.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [2:0] {
    OP_DESEL    = 3'd0,
    OP_RD_BEGIN = 3'd1,
    OP_WR_BEGIN = 3'd2,
    OP_RD_CONT  = 3'd3,
    OP_WR_CONT  = 3'd4,
    OP_RD_SUSP  = 3'd5,
    OP_WR_SUSP  = 3'd6
  } sbc_op_e;

  function automatic logic op_is_begin(sbc_op_e o);
    return (o == OP_RD_BEGIN) || (o == OP_WR_BEGIN);
  endfunction

  function automatic logic op_is_cont(sbc_op_e o);
    return (o == OP_RD_CONT) || (o == OP_WR_CONT);
  endfunction

  function automatic logic op_is_write(sbc_op_e o);
    return (o == OP_WR_BEGIN) || (o == OP_WR_CONT) || (o == OP_WR_SUSP);
  endfunction

  // Select the read or write flavour of a burst step
  function automatic sbc_op_e pick_step(logic wr, logic advance);
    if (advance) return wr ? OP_WR_CONT : OP_RD_CONT;
    return wr ? OP_WR_SUSP : OP_RD_SUSP;
  endfunction

endpackage

// File: rtl/sbc_lane_decode.sv
module sbc_lane_decode #(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [LANES-1:0] lane_mask,
  output logic             wr_req
);
  // Global write wins over the per-lane selects
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i] = ~gw_n | (~bwe_n & ~bsel_n[i]);
  end

  assign wr_req = |lane_mask;

  always_comb begin
    a_r8_global_all_lanes: assert (gw_n || (&lane_mask) || $isunknown(gw_n));
  end
endmodule

// File: rtl/sbc_op_classify.sv
module sbc_op_classify
  import sbc_pkg::*;
(
  input  logic    chip_on,
  input  logic    ps_n,
  input  logic    cs_n,
  input  logic    adv_n,
  input  logic    wr_req,
  input  logic    burst_on,
  output sbc_op_e op_next,
  output logic    strobe_any
);
  assign strobe_any = ~ps_n | ~cs_n;

  always_comb begin
    if (strobe_any) begin
      if (!chip_on)   op_next = OP_DESEL;
      else if (!ps_n) op_next = OP_RD_BEGIN;
      else            op_next = wr_req ? OP_WR_BEGIN : OP_RD_BEGIN;
    end else if (!burst_on) begin
      op_next = OP_DESEL;
    end else begin
      op_next = pick_step(wr_req, ~adv_n);
    end
  end
endmodule

// File: rtl/sbc_burst_track.sv
module sbc_burst_track
  import sbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sbc_op_e op_next,
  output logic    burst_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   burst_on <= 1'b0;
    else if (op_next == OP_DESEL) burst_on <= 1'b0;
    else if (op_is_begin(op_next)) burst_on <= 1'b1;
  end

  // R7: a burst cannot be alive right after a deselect decision
  a_r7_desel_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (op_next == OP_DESEL) |=> !burst_on);
endmodule

// File: rtl/sbc_cmd_decoder.sv
module sbc_cmd_decoder
  import sbc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             ps_n,
  input  logic             cs_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [2:0]       op,
  output logic             addr_load,
  output logic             cnt_adv,
  output logic [LANES-1:0] byte_we
);
  logic             chip_on;
  logic             sec_on;
  logic [LANES-1:0] lane_mask;
  logic             wr_req;
  logic             burst_on;
  logic             strobe_any;
  sbc_op_e          op_next;
  sbc_op_e          op_q;
  logic             load_q;
  logic             adv_q;
  logic [LANES-1:0] we_q;

  assign sec_on  = ce2 & ~ce3_n;
  assign chip_on = ~ce1_n & sec_on;

  sbc_lane_decode #(.LANES(LANES)) u_lanes (
    .gw_n      (gw_n),
    .bwe_n     (bwe_n),
    .bsel_n    (bsel_n),
    .lane_mask (lane_mask),
    .wr_req    (wr_req)
  );

  sbc_op_classify u_class (
    .chip_on    (chip_on),
    .ps_n       (ps_n),
    .cs_n       (cs_n),
    .adv_n      (adv_n),
    .wr_req     (wr_req),
    .burst_on   (burst_on),
    .op_next    (op_next),
    .strobe_any (strobe_any)
  );

  sbc_burst_track u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_next  (op_next),
    .burst_on (burst_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_DESEL;
      load_q <= 1'b0;
      adv_q  <= 1'b0;
      we_q   <= '0;
    end else begin
      op_q   <= op_next;
      load_q <= op_is_begin(op_next);
      adv_q  <= op_is_cont(op_next);
      we_q   <= op_is_write(op_next) ? lane_mask : '0;
    end
  end

  assign op        = op_q;
  assign addr_load = load_q;
  assign cnt_adv   = adv_q;
  assign byte_we   = we_q;

  // R2: primary enable off during a strobe cycle gives deselect
  a_r2_ce1_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && strobe_any) |=> (op == 3'd0 && !addr_load && byte_we == '0));
  // R3: secondary enable condition false during a strobe cycle gives deselect
  a_r3_sec_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_on && strobe_any) |=> (op == 3'd0));
  // R4: enabled processor strobe always gives a read begin
  a_r4_proc_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!ps_n && chip_on) |=> (op == 3'd1 && addr_load && byte_we == '0));
  // R6: load and advance pulses are exclusive and match their operation class
  a_r6_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_load && cnt_adv));
  a_r6_adv_on_cont: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_adv |-> (op == 3'd3 || op == 3'd4));
  // R7: idle cycle after a deselect stays deselected
  a_r7_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 && !strobe_any) |=> (op == 3'd0));
  // R9: write strobes appear only on write operations
  a_r9_we_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we != '0) |-> (op == 3'd2 || op == 3'd4 || op == 3'd6));
endmodule

// File: tb/tb_sbc_cmd_decoder.sv
module tb_sbc_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic       ps_n = 1'b1, cs_n = 1'b1, adv_n = 1'b1;
  logic       gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0] bsel_n = 4'hF;
  logic [2:0] op;
  logic       addr_load, cnt_adv;
  logic [3:0] byte_we;

  typedef struct {
    logic [2:0] op;
    logic       ld;
    logic       ad;
    logic [3:0] we;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   m_burst = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  sbc_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .ps_n(ps_n), .cs_n(cs_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bsel_n(bsel_n), .op(op), .addr_load(addr_load), .cnt_adv(cnt_adv),
    .byte_we(byte_we)
  );

  task automatic cmp(string req, exp_t e);
    checks++;
    if (op !== e.op || addr_load !== e.ld || cnt_adv !== e.ad || byte_we !== e.we) begin
      errors++;
      $display("FAIL %s: got op=%0d ld=%0b adv=%0b we=%h, expected op=%0d ld=%0b adv=%0b we=%h",
               req, op, addr_load, cnt_adv, byte_we, e.op, e.ld, e.ad, e.we);
    end
  endtask

  // Driver: apply one cycle of inputs and predict the registered result
  task automatic cyc(string req, logic e1, logic e2, logic e3, logic p, logic c,
                     logic a, logic g, logic b, logic [3:0] s);
    exp_t e;
    logic [3:0] mask;
    bit wr;
    @(negedge clk);
    ce1_n = e1; ce2 = e2; ce3_n = e3; ps_n = p; cs_n = c; adv_n = a;
    gw_n = g; bwe_n = b; bsel_n = s;
    case ({g, b})
      2'b00, 2'b01: mask = 4'hF;
      2'b10:        mask = ~s;
      default:      mask = 4'h0;
    endcase
    wr = (mask != 4'h0);
    if (!p || !c) begin
      if (e1 || !e2 || e3) e.op = 3'd0;
      else if (!p)         e.op = 3'd1;
      else                 e.op = wr ? 3'd2 : 3'd1;
    end else if (!m_burst) e.op = 3'd0;
    else if (!a)           e.op = wr ? 3'd4 : 3'd3;
    else                   e.op = wr ? 3'd6 : 3'd5;
    if (e.op == 3'd0) m_burst = 0;
    if (e.op == 3'd1 || e.op == 3'd2) m_burst = 1;
    e.ld  = (e.op == 3'd1 || e.op == 3'd2);
    e.ad  = (e.op == 3'd3 || e.op == 3'd4);
    e.we  = (e.op == 3'd2 || e.op == 3'd4 || e.op == 3'd6) ? mask : 4'h0;
    e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compare after each edge that follows a pushed prediction
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        #2;
        cmp(e.req, e);
      end
    end
  end

  initial begin
    exp_t z;
    z.op = 3'd0; z.ld = 1'b0; z.ad = 1'b0; z.we = 4'h0; z.req = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1", z);
    rst_n = 1'b1;
    // R1 / R7: idle after reset
    cyc("R1", 0, 1, 0, 1, 1, 0, 0, 0, 4'h0);
    cyc("R7", 0, 1, 0, 1, 1, 1, 1, 1, 4'hF);
    // R4: processor strobe ignores write inputs
    cyc("R4", 0, 1, 0, 0, 1, 1, 0, 0, 4'h0);
    // R6/R8: continue as global write, enables dropped
    cyc("R8", 1, 0, 1, 1, 1, 0, 0, 1, 4'hF);
    // R6/R9: suspend as partial write
    cyc("R9", 1, 1, 0, 1, 1, 1, 1, 0, 4'h5);
    cyc("R6", 0, 0, 0, 1, 1, 0, 1, 1, 4'h0);
    cyc("R6", 0, 1, 0, 1, 1, 1, 1, 1, 4'hF);
    // R2: primary enable off with controller strobe, then idle
    cyc("R2", 1, 1, 0, 1, 0, 0, 0, 0, 4'h0);
    cyc("R7", 0, 1, 0, 1, 1, 0, 0, 0, 4'h0);
    // R2: processor strobe masked by primary enable
    cyc("R2", 1, 1, 0, 0, 1, 0, 1, 1, 4'hF);
    // R3: secondary condition false
    cyc("R3", 0, 0, 0, 1, 0, 0, 0, 0, 4'h0);
    cyc("R3", 0, 1, 1, 0, 1, 0, 1, 1, 4'hF);
    cyc("R7", 0, 1, 0, 1, 1, 0, 1, 1, 4'hF);
    // R5/R9: controller-strobe write of one lane
    cyc("R5", 0, 1, 0, 1, 0, 1, 1, 0, 4'hE);
    cyc("R9", 0, 1, 0, 1, 1, 0, 1, 0, 4'h6);
    // R5: controller-strobe read, no write enables
    cyc("R5", 0, 1, 0, 1, 0, 0, 1, 1, 4'h0);
    // R9: enable low, all selects high -> read
    cyc("R9", 0, 1, 0, 1, 0, 0, 1, 0, 4'hF);
    // R4: both strobes, writes asserted -> read
    cyc("R4", 0, 1, 0, 0, 0, 0, 0, 0, 4'h0);
    // R10: back-to-back begins with varied lanes
    for (int i = 0; i < 16; i++)
      cyc("R10", 0, 1, 0, 1, 0, 1, 1, 0, i[3:0]);
    cyc("R8", 0, 1, 0, 1, 0, 1, 0, 1, 4'hF);
    cyc("R6", 1, 0, 1, 1, 1, 1, 1, 1, 4'hF);
    cyc("R6", 1, 0, 1, 1, 1, 0, 1, 1, 4'hF);
    cyc("R7", 0, 1, 0, 1, 1, 1, 1, 1, 4'hF);
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule